// File: doc/BRIEF.md
# Audio Processor Control Write Receiver

This block is the serial control port of a two-channel audio processor. It sits on an I2C bus as a write-only target and takes its timing from a fast system clock. It passes SCL and SDA through synchronizers, finds the start and stop conditions, and shifts in bytes on the rising edges of SCL. A transfer carries three bytes. The first byte is a 7-bit device address with a write bit; the lowest address bit comes from a strap pin, so two instances can share one bus. The second byte is a subaddress that selects one of eight settings registers. The third byte is the value to store.

The stored settings are presented in parallel on output ports: volume left and right for each channel, bass and treble levels, a switch word for the main channel and a switch word for the second channel. The switch word of the main channel contains the mute control. Reset forces mute on, and it stays on until software writes that switch word. The block acknowledges every byte it accepts by pulling SDA low during the ninth clock. Any bytes that follow the data byte are acknowledged and then discarded.

Top module: `audio_ctl_i2c_rx`

## Requirements
- R1: A falling SDA while SCL is high is a start condition, and a rising SDA while SCL is high is a stop condition. A start at any point, including the middle of a byte, returns the receiver to waiting for an address byte.
- R2: The device address is the 7-bit value {ADDR_HI, addrStrap}, which is 0b100010s by default. The first byte is {address, rw} with the MSB first. When the address matches and rw is 0, the block drives sdaPullLow high during the ninth SCL clock. The block only starts pulling SDA low while SCL is low.
- R3: When the address does not match, or when rw is 1, the block does not acknowledge that byte or any later byte, and writes nothing, until the next start condition.
- R4: The subaddress selects a register as follows. 0x00 is ch1VolL, 0x01 is ch1VolR, 0x02 is bassLvl, 0x03 is trebleLvl, 0x08 is ch1Sw, 0x04 is ch2VolL, 0x05 is ch2VolR and 0x0C is ch2Sw. Any other subaddress is still acknowledged, but its data byte changes no output.
- R5: A volume register takes data bits [5:0]. A bass or treble register takes data bits [3:0]. All other data bits are dropped.
- R6: ch1Sw takes data bits [5:0]: bit 5 is mute, bit 4 and bit 3 select the stereo effect, bits 2:1 select the sound mode and bit 0 selects the input. ch2Sw[2:0] takes data bits [3:1]: bit 3 is the external switch and bits 2:1 select the sound mode.
- R7: After reset every output register is zero, except that ch1Sw is 0x20 (mute on). sdaPullLow is low.
- R8: A register is written only by a data byte that follows a matching address byte and a subaddress byte within the same transfer. A transfer that ends before its data byte changes nothing.
- R9: Each byte after the data byte in the same transfer is acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Active-low reset, puts all registers in their reset state |
| sclIn | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Serial data from the bus, as seen on the wire |
| addrStrap | input | 1 | Strap that sets the lowest device address bit |
| sdaPullLow | output | 1 | When high, the external driver pulls SDA low |
| ch1VolL | output | 6 | Main channel volume, left |
| ch1VolR | output | 6 | Main channel volume, right |
| bassLvl | output | 4 | Bass level |
| trebleLvl | output | 4 | Treble level |
| ch1Sw | output | 6 | Main channel switches (bit 5 mute) |
| ch2VolL | output | 6 | Second channel volume, left |
| ch2VolR | output | 6 | Second channel volume, right |
| ch2Sw | output | 3 | Second channel switches |

## Verification
The hardest case to reach from the ports is a start condition that arrives while a byte is half received. The receiver must then throw away its partial shift state and still accept a new frame at once. The bench covers this with a directed sequence. It sends the address, then three bits of a subaddress, then a repeated start, and then a complete frame. After that it checks that only the second frame's data landed. Random frames vary the strap value, the address and the subaddress, so that mismatched addresses and unmapped subaddresses occur alongside the valid writes.

// File: rtl/actl_pkg.sv
package actl_pkg;
  localparam int NUM_REGS = 8;
  localparam int VOL_W    = 6;
  localparam int TONE_W   = 4;
  localparam int SW1_W    = 6;
  localparam int SW2_W    = 3;
  localparam int REG_W    = (VOL_W > SW1_W) ? VOL_W : SW1_W;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // register slots
  localparam int IX_V1L = 0, IX_V1R = 1, IX_BAS = 2, IX_TRE = 3;
  localparam int IX_SW1 = 4, IX_V2L = 5, IX_V2R = 6, IX_SW2 = 7;

  typedef struct packed {
    logic shiftEn;
    logic subLoad;
    logic dataWr;
  } ctlStrobe_t;

  // {valid, index}
  function automatic logic [IDX_W:0] subToIdx(input logic [7:0] sub);
    case (sub)
      8'h00:   subToIdx = {1'b1, 3'(IX_V1L)};
      8'h01:   subToIdx = {1'b1, 3'(IX_V1R)};
      8'h02:   subToIdx = {1'b1, 3'(IX_BAS)};
      8'h03:   subToIdx = {1'b1, 3'(IX_TRE)};
      8'h08:   subToIdx = {1'b1, 3'(IX_SW1)};
      8'h04:   subToIdx = {1'b1, 3'(IX_V2L)};
      8'h05:   subToIdx = {1'b1, 3'(IX_V2R)};
      8'h0C:   subToIdx = {1'b1, 3'(IX_SW2)};
      default: subToIdx = '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] regMask(input int idx);
    case (idx)
      IX_BAS, IX_TRE: regMask = REG_W'((1 << TONE_W) - 1);
      IX_SW2:         regMask = REG_W'(((1 << SW2_W) - 1) << 1);
      default:        regMask = REG_W'((1 << VOL_W) - 1);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] regReset(input int idx);
    regReset = (idx == IX_SW1) ? REG_W'(1 << (SW1_W - 1)) : '0;
  endfunction
endpackage

// File: rtl/actl_bus_ctrl.sv
module actl_bus_ctrl
  import actl_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b100010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrStrap,
  input  logic [7:0] shiftByte,
  output logic       sdaBit,
  output ctlStrobe_t strobe,
  output logic       sdaPullLow
);
  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_ACK} busState_t;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startDet, stopDet, addrOk;
  busState_t  state;
  logic [3:0] bitCnt;
  logic [1:0] byteIdx;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin sclSync[0] <= 1'b1; sdaSync[0] <= 1'b1; end
          else       begin sclSync[0] <= sclIn; sdaSync[0] <= sdaIn; end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) begin sclSync[i] <= 1'b1; sdaSync[i] <= 1'b1; end
          else       begin sclSync[i] <= sclSync[i-1]; sdaSync[i] <= sdaSync[i-1]; end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];
  assign sdaBit = sdaS;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin sclP <= 1'b1; sdaP <= 1'b1; end
    else       begin sclP <= sclS; sdaP <= sdaS; end

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign addrOk   = (shiftByte[7:1] == {ADDR_HI, addrStrap}) && !shiftByte[0];

  always_comb begin
    strobe = '0;
    if (state == ST_BITS && !startDet && !stopDet) begin
      strobe.shiftEn = sclRise && (bitCnt < 4'd8);
      if (sclFall && bitCnt == 4'd8) begin
        strobe.subLoad = (byteIdx == 2'd1);
        strobe.dataWr  = (byteIdx == 2'd2);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; byteIdx <= '0; sdaPullLow <= 1'b0;
    end else if (startDet) begin
      state <= ST_BITS; bitCnt <= '0; byteIdx <= '0; sdaPullLow <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE; sdaPullLow <= 1'b0;
    end else begin
      case (state)
        ST_BITS: begin
          if (sclRise && bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
          if (sclFall && bitCnt == 4'd8) begin
            if (byteIdx == 2'd0 && !addrOk) state <= ST_IDLE;
            else begin state <= ST_ACK; sdaPullLow <= 1'b1; end
          end
        end
        ST_ACK: begin
          if (sclRise) bitCnt <= 4'd9;
          if (sclFall && bitCnt == 4'd9) begin
            state <= ST_BITS; bitCnt <= '0; sdaPullLow <= 1'b0;
            if (byteIdx != 2'd3) byteIdx <= byteIdx + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS); // R2
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (!sdaPullLow && state == ST_BITS && byteIdx == 2'd0)); // R1
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow); // R3
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd9); // R1
endmodule

// File: rtl/actl_regfile.sv
module actl_regfile
  import actl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              sdaBit,
  output logic [7:0]        shiftByte,
  output logic [VOL_W-1:0]  ch1VolL,
  output logic [VOL_W-1:0]  ch1VolR,
  output logic [TONE_W-1:0] bassLvl,
  output logic [TONE_W-1:0] trebleLvl,
  output logic [SW1_W-1:0]  ch1Sw,
  output logic [VOL_W-1:0]  ch2VolL,
  output logic [VOL_W-1:0]  ch2VolR,
  output logic [SW2_W-1:0]  ch2Sw
);
  logic [7:0]       subReg;
  logic [IDX_W:0]   selIdx;
  logic [REG_W-1:0] regs [NUM_REGS];
  logic [NUM_REGS*REG_W-1:0] regFlat;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      shiftByte <= '0; subReg <= '0;
    end else begin
      if (strobe.shiftEn) shiftByte <= {shiftByte[6:0], sdaBit};
      if (strobe.subLoad) subReg <= shiftByte;
    end

  assign selIdx = subToIdx(subReg);

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) regs[r] <= regReset(r);
        else if (strobe.dataWr && selIdx[IDX_W] && selIdx[IDX_W-1:0] == IDX_W'(r))
          regs[r] <= shiftByte[REG_W-1:0] & regMask(r);
      assign regFlat[r*REG_W +: REG_W] = regs[r];
    end
  endgenerate

  assign ch1VolL   = regs[IX_V1L][VOL_W-1:0];
  assign ch1VolR   = regs[IX_V1R][VOL_W-1:0];
  assign bassLvl   = regs[IX_BAS][TONE_W-1:0];
  assign trebleLvl = regs[IX_TRE][TONE_W-1:0];
  assign ch1Sw     = regs[IX_SW1][SW1_W-1:0];
  assign ch2VolL   = regs[IX_V2L][VOL_W-1:0];
  assign ch2VolR   = regs[IX_V2R][VOL_W-1:0];
  assign ch2Sw     = regs[IX_SW2][SW2_W:1];

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataWr |=> $stable(regFlat)); // R8
endmodule

// File: rtl/audio_ctl_i2c_rx.sv
module audio_ctl_i2c_rx
  import actl_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b100010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  output logic              sdaPullLow,
  output logic [VOL_W-1:0]  ch1VolL,
  output logic [VOL_W-1:0]  ch1VolR,
  output logic [TONE_W-1:0] bassLvl,
  output logic [TONE_W-1:0] trebleLvl,
  output logic [SW1_W-1:0]  ch1Sw,
  output logic [VOL_W-1:0]  ch2VolL,
  output logic [VOL_W-1:0]  ch2VolR,
  output logic [SW2_W-1:0]  ch2Sw
);
  ctlStrobe_t strobe;
  logic [7:0] shiftByte;
  logic sdaBit;

  actl_bus_ctrl #(.ADDR_HI(ADDR_HI), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrStrap(addrStrap),
    .shiftByte(shiftByte), .sdaBit(sdaBit), .strobe(strobe), .sdaPullLow(sdaPullLow)
  );

  actl_regfile u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit), .shiftByte(shiftByte),
    .ch1VolL(ch1VolL), .ch1VolR(ch1VolR), .bassLvl(bassLvl), .trebleLvl(trebleLvl),
    .ch1Sw(ch1Sw), .ch2VolL(ch2VolL), .ch2VolR(ch2VolR), .ch2Sw(ch2Sw)
  );
endmodule

// File: tb/audio_ctl_i2c_rx_bench.sv
module audio_ctl_i2c_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 6;
  localparam int HIGH = 16;
  localparam logic [5:0] DEV_HI = 6'b100010;

  logic clk = 1'b0, rstN = 1'b0, sclIn = 1'b1, sdaM = 1'b1, addrStrap = 1'b0;
  logic sdaLine, sdaPullLow;
  logic [5:0] ch1VolL, ch1VolR, ch1Sw, ch2VolL, ch2VolR;
  logic [3:0] bassLvl, trebleLvl;
  logic [2:0] ch2Sw;
  int checks = 0, fails = 0;
  logic [5:0] expReg [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  audio_ctl_i2c_rx u_audio_ctl_i2c_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaLine), .addrStrap(addrStrap),
    .sdaPullLow(sdaPullLow), .ch1VolL(ch1VolL), .ch1VolR(ch1VolR), .bassLvl(bassLvl),
    .trebleLvl(trebleLvl), .ch1Sw(ch1Sw), .ch2VolL(ch2VolL), .ch2VolR(ch2VolR), .ch2Sw(ch2Sw)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int expIdx(input logic [7:0] s);
    case (s)
      8'h00: return 0; 8'h01: return 1; 8'h02: return 2; 8'h03: return 3;
      8'h08: return 4; 8'h04: return 5; 8'h05: return 6; 8'h0C: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [5:0] expVal(input int idx, input logic [7:0] d);
    case (idx)
      2, 3:    return {2'b00, d[3:0]};
      7:       return {2'b00, d[3:1], 1'b0};
      default: return d[5:0];
    endcase
  endfunction

  function automatic logic [7:0] myAddr();
    return {DEV_HI, addrStrap, 1'b0};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(QTR); sclIn = 1'b1; waitClk(QTR);
    sdaM = 1'b0; waitClk(QTR); sclIn = 1'b0; waitClk(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(QTR); sclIn = 1'b1; waitClk(QTR);
    sdaM = 1'b1; waitClk(QTR);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitClk(QTR); sclIn = 1'b1; waitClk(HIGH); sclIn = 1'b0; waitClk(QTR);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitClk(QTR); sclIn = 1'b1; waitClk(HIGH/2);
    acked = !sdaLine;
    waitClk(HIGH/2); sclIn = 1'b0; waitClk(QTR);
  endtask

  task automatic checkRegs(input string req);
    chk(ch1VolL == expReg[0], {req, " ch1VolL"}, ch1VolL, expReg[0]);
    chk(ch1VolR == expReg[1], {req, " ch1VolR"}, ch1VolR, expReg[1]);
    chk(bassLvl == expReg[2][3:0], {req, " bassLvl"}, bassLvl, expReg[2]);
    chk(trebleLvl == expReg[3][3:0], {req, " trebleLvl"}, trebleLvl, expReg[3]);
    chk(ch1Sw == expReg[4], {req, " ch1Sw"}, ch1Sw, expReg[4]);
    chk(ch2VolL == expReg[5], {req, " ch2VolL"}, ch2VolL, expReg[5]);
    chk(ch2VolR == expReg[6], {req, " ch2VolR"}, ch2VolR, expReg[6]);
    chk(ch2Sw == expReg[7][3:1], {req, " ch2Sw"}, ch2Sw, expReg[7][3:1]);
  endtask

  // full frame; the model is updated from the requirements
  task automatic frame(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d,
                       input string req);
    logic k0, k1, k2;
    logic ok;
    int idx;
    ok = (a == myAddr());
    busStart();
    sendByte(a, k0); sendByte(s, k1); sendByte(d, k2);
    busStop();
    waitClk(4);
    chk(k0 == ok && k1 == ok && k2 == ok, {req, " R2 R3 acks"}, {k0, k1, k2}, {ok, ok, ok});
    idx = expIdx(s);
    if (ok && idx >= 0) expReg[idx] = expVal(idx, d);
    checkRegs(req);
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] a, s, d;
    logic [7:0] validSubs [8];
    void'($urandom(32'h5eed_1234));
    validSubs = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h08, 8'h04, 8'h05, 8'h0C};
    for (int i = 0; i < 8; i++) expReg[i] = 6'h00;
    expReg[4] = 6'h20;
    waitClk(5); rstN = 1'b1; waitClk(3);

    // R7 reset state
    chk(sdaPullLow == 1'b0, "R7 sdaPullLow", sdaPullLow, 0);
    checkRegs("R7");

    // R6 clear mute, then R5 masking of upper bits
    frame(myAddr(), 8'h08, 8'hC0, "R6 mute clear");
    frame(myAddr(), 8'h02, 8'hFF, "R5 bass mask");
    frame(myAddr(), 8'h0C, 8'hFF, "R6 ch2 switches");
    frame(myAddr(), 8'h00, 8'hFF, "R5 volume mask");

    // random frames with strap, address and subaddress variation (R2 R3 R4)
    for (int n = 0; n < 55; n++) begin
      addrStrap = 1'($urandom_range(0, 1));
      a = ($urandom_range(0, 9) < 8) ? myAddr() : 8'($urandom);
      s = ($urandom_range(0, 3) < 3) ? validSubs[$urandom_range(0, 7)] : 8'($urandom);
      d = 8'($urandom);
      frame(a, s, d, "R4 random");
    end

    // R3 read bit refused
    frame(myAddr() | 8'h01, 8'h01, 8'h15, "R3 read bit");
    // R3 strap mismatch
    frame(myAddr() ^ 8'h02, 8'h01, 8'h15, "R3 strap mismatch");
    // R4 unmapped subaddress
    frame(myAddr(), 8'h06, 8'h2A, "R4 unmapped sub");

    // R1 repeated start in the middle of the subaddress byte
    busStart();
    sendByte(myAddr(), ack);
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b0);
    frame(myAddr(), 8'h05, 8'h1B, "R1 restart mid-byte");

    // R8 transfer ending before the data byte
    busStart();
    sendByte(myAddr(), ack);
    sendByte(8'h03, ack);
    chk(ack, "R8 sub ack", ack, 1);
    busStop(); waitClk(4);
    checkRegs("R8 truncated");

    // R9 trailing bytes acked and ignored
    busStart();
    sendByte(myAddr(), ack); sendByte(8'h04, ack); sendByte(8'h11, ack);
    expReg[5] = 6'h11;
    sendByte(8'h08, ack);
    chk(ack, "R9 extra byte 1 ack", ack, 1);
    sendByte(8'h3F, ack);
    chk(ack, "R9 extra byte 2 ack", ack, 1);
    busStop(); waitClk(4);
    checkRegs("R9 trailing");

    // R6 mute set again
    frame(myAddr(), 8'h08, 8'h20, "R6 mute set");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule